// File: doc/BRIEF.md
# Keyed Indirect Configuration Gate

This block sits on a simple register-write bus (address, write data, write strobe) and hides one configuration byte behind a write key. Firmware unlocks the gate by writing three key bytes in a fixed order to one dedicated key address. It then names the internal target through a select register and writes the value through a data register. The byte reached through select code 0x01 controls the serial interface. When that byte holds a configured disable value, the block raises an output that turns off the two-wire serial port. Boards that share the four-wire bus with other devices use this output.

The key matcher tolerates repeated leading bytes: a wrong byte sends it back to the start, but a fresh first key byte counts at once as step one. Once the gate is unlocked, it stays open across any number of select and data writes. A write to any unrelated address closes it again, and so does a new write to the key address. The select register can be read back on the same address lines, so firmware can confirm the target before it commits a data write.

Top module: `cfg_key_gate`

## Requirements
- R1: After reset, the gate is locked, `i2cDisable` is 0, and reading address 0x18 returns 0x00.
- R2: Writing 0x00, then 0x50, then 0xA0 to address 0x1E, with no breaking write in between, unlocks the gate.
- R3: A write to 0x1E that does not match the next expected key byte returns the matcher to its start. If that byte is 0x00, the matcher restarts at step one, so the sequence 00,00,50,A0 still unlocks.
- R4: When the gate is unlocked and the select register holds 0x01, a write to address 0x22 stores the byte in the interface-control register. `i2cDisable` is 1 exactly when that byte equals parameter DISABLE_VAL (default 0x00). Any other stored value clears it.
- R5: While the gate is locked, writes to 0x22 are ignored and `i2cDisable` keeps its value.
- R6: A write to any address other than 0x1E, 0x18 or 0x22 locks the gate and resets the matcher. Writes to 0x18 and 0x22 neither lock the gate nor reset a partial key.
- R7: With `busAddr` at 0x18, `rdData` returns the last byte written to 0x18. Writes to 0x18 are accepted whether the gate is locked or not. At any other address, `rdData` is 0x00.
- R8: When the select register holds a value other than 0x01, data writes leave the interface-control register unchanged.
- R9: Any write to 0x1E while the gate is unlocked locks it again. The matcher restarts at step one if the byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register address for writes and readback |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| rdData | output | 8 | Readback of the select register |
| i2cDisable | output | 1 | High when the two-wire serial port must be disabled |

## Verification
The bench sweeps every byte value at each key position. It checks that only the exact key opens the gate: a matcher that accepts keys out of order, or that forgets the restart on 0x00, would unlock on wrong sequences or miss 00,00,50,A0. It writes every address once after unlocking. A decoder that relocks on select or data writes, or that keeps the gate open after a foreign write, would then give the wrong disable state. It also sweeps every data value and every select code. This catches a wrong disable comparison, data writes that slip through while the gate is locked, and writes that land when another target is selected.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ADDR_KEY_DEF  = 8'h1E;
  localparam logic [BYTE_W-1:0] ADDR_SEL_DEF  = 8'h18;
  localparam logic [BYTE_W-1:0] ADDR_DATA_DEF = 8'h22;
  localparam logic [BYTE_W-1:0] SEL_IFCTRL    = 8'h01;

  typedef struct packed {
    logic loadSel;
    logic loadData;
  } ctlStrobes_t;
endpackage

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
  import cfg_key_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int KEY_LEN = 3,
  parameter logic [KEY_LEN*DATA_W-1:0] KEY_SEQ = 24'hA0_50_00,
  parameter logic [ADDR_W-1:0] KEY_ADDR = ADDR_KEY_DEF,
  parameter logic [ADDR_W-1:0] SEL_ADDR = ADDR_SEL_DEF,
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_DATA_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output ctlStrobes_t       strobes,
  output logic              unlocked
);
  localparam int STEP_W = $clog2(KEY_LEN + 1);
  localparam logic [STEP_W-1:0] STEP_OPEN = STEP_W'(KEY_LEN);

  logic [DATA_W-1:0] keyBytes [KEY_LEN];
  logic [STEP_W-1:0] keyStep, keyStepNext;
  logic [DATA_W-1:0] expectByte;
  logic hitKey, hitSel, hitData;

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign keyBytes[g] = KEY_SEQ[g*DATA_W +: DATA_W];
  end

  assign hitKey  = (busAddr == KEY_ADDR);
  assign hitSel  = (busAddr == SEL_ADDR);
  assign hitData = (busAddr == DATA_ADDR);
  assign unlocked = (keyStep == STEP_OPEN);

  always_comb begin
    expectByte = keyBytes[0];
    for (int i = 0; i < KEY_LEN; i++) begin
      if (keyStep == STEP_W'(i)) expectByte = keyBytes[i];
    end
  end

  always_comb begin
    keyStepNext = keyStep;
    if (busWe) begin
      if (hitKey) begin
        if (!unlocked && busWdata == expectByte) keyStepNext = keyStep + STEP_W'(1);
        else if (busWdata == keyBytes[0])        keyStepNext = STEP_W'(1);
        else                                     keyStepNext = '0;
      end else if (!(hitSel || hitData)) begin
        keyStepNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyStep <= '0;
    else       keyStep <= keyStepNext;
  end

  always_comb begin
    strobes.loadSel  = busWe && hitSel;
    strobes.loadData = busWe && hitData && unlocked;
  end
endmodule

// File: rtl/cfg_key_dp.sv
module cfg_key_dp
  import cfg_key_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR = ADDR_SEL_DEF,
  parameter logic [DATA_W-1:0] CTRL_CODE = SEL_IFCTRL,
  parameter logic [DATA_W-1:0] DISABLE_VAL = 8'h00,
  parameter logic [DATA_W-1:0] CTRL_RESET = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              i2cDisable
);
  logic [DATA_W-1:0] selReg;
  logic [DATA_W-1:0] ctrlReg;
  logic loadCtrl;

  assign loadCtrl = strobes.loadData && (selReg == CTRL_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      ctrlReg <= CTRL_RESET;
    end else begin
      if (strobes.loadSel) selReg  <= busWdata;
      if (loadCtrl)        ctrlReg <= busWdata;
    end
  end

  assign rdData     = (busAddr == SEL_ADDR) ? selReg : '0;
  assign i2cDisable = (ctrlReg == DISABLE_VAL);
endmodule

// File: rtl/cfg_key_gate.sv
module cfg_key_gate
  import cfg_key_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int KEY_LEN = 3,
  parameter logic [KEY_LEN*DATA_W-1:0] KEY_SEQ = 24'hA0_50_00,
  parameter logic [ADDR_W-1:0] KEY_ADDR = ADDR_KEY_DEF,
  parameter logic [ADDR_W-1:0] SEL_ADDR = ADDR_SEL_DEF,
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_DATA_DEF,
  parameter logic [DATA_W-1:0] CTRL_CODE = SEL_IFCTRL,
  parameter logic [DATA_W-1:0] DISABLE_VAL = 8'h00,
  parameter logic [DATA_W-1:0] CTRL_RESET = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] rdData,
  output logic              i2cDisable
);
  ctlStrobes_t strobes;
  logic unlocked;

  cfg_key_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .KEY_SEQ(KEY_SEQ),
    .KEY_ADDR(KEY_ADDR), .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .strobes(strobes), .unlocked(unlocked)
  );

  cfg_key_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR), .CTRL_CODE(CTRL_CODE),
    .DISABLE_VAL(DISABLE_VAL), .CTRL_RESET(CTRL_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .strobes(strobes), .rdData(rdData), .i2cDisable(i2cDisable)
  );
endmodule

// File: rtl/cfg_key_gate_chk.sv
module cfg_key_gate_chk
  import cfg_key_pkg::*;
#(
  parameter logic [7:0] KEY_ADDR = ADDR_KEY_DEF,
  parameter logic [7:0] SEL_ADDR = ADDR_SEL_DEF,
  parameter logic [7:0] DATA_ADDR = ADDR_DATA_DEF,
  parameter logic [7:0] KEY_LAST = 8'hA0
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busAddr,
  input logic [7:0] busWdata,
  input logic       busWe,
  input logic [7:0] rdData,
  input logic       i2cDisable,
  input logic       unlocked
);
  logic otherAddr;
  assign otherAddr = busAddr != KEY_ADDR && busAddr != SEL_ADDR && busAddr != DATA_ADDR;

  // R5: locked data writes leave the disable output alone
  p_locked_ignore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DATA_ADDR && !unlocked) |=> $stable(i2cDisable));

  // R2: opening happens only on the final key byte
  p_open_on_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(busWe && busAddr == KEY_ADDR && busWdata == KEY_LAST));

  // R6: a foreign address closes the gate
  p_foreign_locks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && otherAddr) |=> !unlocked);

  // R9: a key-address write while open closes the gate
  p_rekey_locks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == KEY_ADDR && unlocked) |=> !unlocked);

  // R7: select readback follows the last select write
  p_sel_readback_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == SEL_ADDR) |=> (busAddr != SEL_ADDR || rdData == $past(busWdata)));

  // R4: the output moves only after an accepted data write
  p_disable_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(i2cDisable) |-> $past(busWe && busAddr == DATA_ADDR && unlocked));
endmodule

bind cfg_key_gate cfg_key_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
  .rdData(rdData), .i2cDisable(i2cDisable), .unlocked(unlocked)
);

// File: tb/sim_cfg_key_gate.sv
module sim_cfg_key_gate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWdata = 8'h00;
  logic busWe = 1'b0;
  logic [7:0] rdData;
  logic i2cDisable;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  cfg_key_gate u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .rdData(rdData), .i2cDisable(i2cDisable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'h00;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic key3(input logic [7:0] k0, input logic [7:0] k1, input logic [7:0] k2);
    wr(8'h1E, k0); wr(8'h1E, k1); wr(8'h1E, k2);
  endtask

  task automatic readSel(output logic [7:0] v);
    @(negedge clk);
    busAddr = 8'h18;
    #1 v = rdData;
    busAddr = 8'h00;
  endtask

  initial begin
    logic [7:0] v;
    doReset();
    // R1: reset state
    check("R1 disable", i2cDisable, 0);
    readSel(v);
    check("R1 select", v, 0);
    busAddr = 8'h22;
    #1 check("R7 non-select read", rdData, 0);
    busAddr = 8'h00;

    // R5: locked data write ignored (select 01 set while locked)
    wr(8'h18, 8'h01); wr(8'h22, 8'h00);
    check("R5 locked data", i2cDisable, 0);

    // R2/R4: each key position swept
    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] k [3];
        k[0] = 8'h00; k[1] = 8'h50; k[2] = 8'hA0;
        k[p] = 8'(b);
        doReset();
        wr(8'h18, 8'h01);
        key3(k[0], k[1], k[2]);
        wr(8'h22, 8'h00);
        check("R2 key sweep", i2cDisable, (k[0] == 8'h00 && k[1] == 8'h50 && k[2] == 8'hA0) ? 1 : 0);
      end
    end

    // R3: repeated leading byte restarts at step one; wrong byte resets
    doReset(); wr(8'h18, 8'h01);
    wr(8'h1E, 8'h00); key3(8'h00, 8'h50, 8'hA0); wr(8'h22, 8'h00);
    check("R3 restart on 00", i2cDisable, 1);
    doReset(); wr(8'h18, 8'h01);
    wr(8'h1E, 8'h00); wr(8'h1E, 8'h50); wr(8'h1E, 8'h33); wr(8'h1E, 8'hA0); wr(8'h22, 8'h00);
    check("R3 wrong byte resets", i2cDisable, 0);
    doReset(); wr(8'h18, 8'h01);
    wr(8'h1E, 8'h00); wr(8'h1E, 8'h50); wr(8'h1E, 8'h00); wr(8'h1E, 8'h50); wr(8'h1E, 8'hA0);
    wr(8'h22, 8'h00);
    check("R3 restart mid key", i2cDisable, 1);

    // R6: select/data writes during a partial key keep progress
    doReset();
    wr(8'h1E, 8'h00); wr(8'h18, 8'h01); wr(8'h1E, 8'h50); wr(8'h22, 8'h00); wr(8'h1E, 8'hA0);
    wr(8'h22, 8'h00);
    check("R6 partial kept", i2cDisable, 1);
    doReset();
    wr(8'h18, 8'h01); wr(8'h1E, 8'h00); wr(8'h1E, 8'h50); wr(8'h40, 8'h00); wr(8'h1E, 8'hA0);
    wr(8'h22, 8'h00);
    check("R6 partial broken", i2cDisable, 0);

    // R6/R9: every address written after unlocking
    for (int a = 0; a < 256; a++) begin
      int exp;
      doReset();
      wr(8'h18, 8'h01);
      key3(8'h00, 8'h50, 8'hA0);
      wr(8'(a), 8'h01);
      wr(8'h22, 8'h00);
      exp = (a == 8'h18 || a == 8'h22) ? 1 : 0;
      check(a == 8'h1E ? "R9 rekey locks" : "R6 address sweep", i2cDisable, exp);
    end

    // R4: every data value while open
    doReset(); wr(8'h18, 8'h01); key3(8'h00, 8'h50, 8'hA0);
    for (int d = 0; d < 256; d++) begin
      wr(8'h22, 8'(d));
      check("R4 data sweep", i2cDisable, d == 0 ? 1 : 0);
    end
    // R4: re-enable after disable
    wr(8'h22, 8'h00); wr(8'h22, 8'h40);
    check("R4 re-enable", i2cDisable, 0);

    // R8: every select code while open
    for (int s = 0; s < 256; s++) begin
      doReset(); key3(8'h00, 8'h50, 8'hA0);
      wr(8'h18, 8'(s)); wr(8'h22, 8'h00);
      check("R8 select sweep", i2cDisable, s == 1 ? 1 : 0);
    end

    // R5: locked after disable, data write cannot re-enable
    doReset(); wr(8'h18, 8'h01); key3(8'h00, 8'h50, 8'hA0); wr(8'h22, 8'h00);
    wr(8'h55, 8'h00); wr(8'h22, 8'h40);
    check("R5 locked keeps disable", i2cDisable, 1);

    // R7: select readback for every value, locked
    doReset();
    for (int s = 0; s < 256; s++) begin
      wr(8'h18, 8'(s));
      readSel(v);
      check("R7 readback", v, s);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule